// File: doc/BRIEF.md
# Text Stream Cursor Formatter

The formatter sits between a producer of text and the register port of a character LCD with three rows of sixteen columns. It takes one byte at a time on a valid/ready input stream and emits a valid/ready stream of LCD register writes. Each write is a register-select bit plus a byte. The formatter keeps its own record of the cursor row and column. Printable bytes become data writes. Tab, carriage return and newline are expanded into padding spaces and address-set commands. Alongside characters, the input stream carries a small set of control requests, marked by a separate flag bit: clear the screen, return home, and point the character generator at an address.

Back-pressure works as follows. An output word stays on `out_rs`/`out_byte` with `out_valid` high until `out_ready` is seen high at a clock edge. The output holds one word. The input is accepted only when no expansion is in flight and the output word is either empty or leaving in that same cycle. The next input byte is therefore never taken before every write produced by the previous byte has been loaded, and all but the last of those writes have already left. Dropped inputs (NUL and the reserved request) are consumed in one handshake and produce no write.

Top module: `txt_cursor_fmt`

## Requirements
- R1: After reset `out_valid` is low, `in_ready` is high, and the tracked position is row 1, column 1.
- R2: With `in_cmd`=0, a byte that is not 0x00, 0x09, 0x0A or 0x0D produces one write with `out_rs`=1 (data) and that byte, and the column advances by one.
- R3: After a data write in column 16 the column becomes 1 and the row advances; advancing past row 3 gives row 1.
- R4: A carriage return (0x0D) produces one write with `out_rs`=0 (command) and byte 0x80 | ((row-1)*16), and the column becomes 1.
- R5: A tab (0x09) produces TAB_LEN (default 4) data writes of 0x20, each advancing the position as in R2 and R3.
- R6: A newline (0x0A) produces data writes of 0x20 while the column is below 16, advancing it each time. It then produces the command 0x80 | ((r-1)*16), where r is the next row (row 3 is followed by row 1), and leaves the position at row r, column 1.
- R7: A request with `in_cmd`=1 and `in_data[7:6]`=00 emits command 0x01. One with `in_data[7:6]`=01 emits command 0x02. Both set the position to row 1, column 1.
- R8: A request with `in_cmd`=1 and `in_data[7:6]`=10 emits command 0x40 | `in_data[5:0]` and leaves the position unchanged.
- R9: A data byte 0x00, and a request with `in_data[7:6]`=11, are consumed with no write and no change of position.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_rs` and `out_byte` hold their values.
- R11: `in_ready` is low while a tab or newline expansion is in progress, and while an output word is held without `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Formatter accepts the offered byte this cycle |
| in_cmd | input | 1 | 1: `in_data` is a control request; 0: text byte |
| in_data | input | 8 | Text byte, or request code in [7:6] with argument in [5:0] |
| out_valid | output | 1 | An LCD register write is offered |
| out_ready | input | 1 | The LCD side takes the offered write this cycle |
| out_rs | output | 1 | Register select: 1 data, 0 command |
| out_byte | output | 8 | Byte to write |

## Verification
The main function is exercised with several kinds of text. Plain strings show the column count and the 16-to-1 wrap into the next row. A tab placed at column 14 tells the tab expansion apart from a plain space count, because the padding must cross both a row wrap and the wrap from row 3 to row 1. Newlines are issued from mid-line, from column 1 and from column 16, and on rows 1 and 3. These separate the padding length from the row-advance and wrap. A carriage return after each stretch exposes the tracked row as an address command. The same traffic is repeated under a pseudo-random `out_ready` pattern, to separate correct stalling of input and output from the formatting itself.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

  localparam int DDADDR_W = 7;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PAD  = 2'd1,
    SEQ_MOVE = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_CLEAR  = 2'b00,
    OP_HOME   = 2'b01,
    OP_CGADDR = 2'b10,
    OP_NONE   = 2'b11
  } ctl_op_e;

  localparam logic [7:0] CH_NUL   = 8'h00;
  localparam logic [7:0] CH_TAB   = 8'h09;
  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_SPACE = 8'h20;

  localparam logic [7:0] LCD_CLEAR  = 8'h01;
  localparam logic [7:0] LCD_HOME   = 8'h02;
  localparam logic [7:0] LCD_CGADDR = 8'h40;
  localparam logic [7:0] LCD_DDADDR = 8'h80;

  typedef struct packed {
    logic       rs;
    logic [7:0] val;
  } lcd_word_t;

endpackage

// File: rtl/fmt_cursor.sv
module fmt_cursor
  import fmt_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 16,
  parameter int RW   = 2,
  parameter int CW   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                go_origin,
  input  logic                go_line_start,
  input  logic                go_next_line,
  output logic [RW-1:0]       row_q,
  output logic [CW-1:0]       col_q,
  output logic [DDADDR_W-1:0] line_addr,
  output logic [DDADDR_W-1:0] next_line_addr,
  output logic [CW-1:0]       pad_len
);

  logic          last_row;
  logic          last_col;
  logic [RW-1:0] row_next;

  assign last_row = (int'(row_q) == ROWS - 1);
  assign last_col = (int'(col_q) == COLS - 1);
  assign row_next = last_row ? '0 : row_q + RW'(1);
  assign pad_len  = CW'(COLS - 1) - col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (go_origin) begin
      row_q <= '0;
      col_q <= '0;
    end else if (go_next_line) begin
      row_q <= row_next;
      col_q <= '0;
    end else if (go_line_start) begin
      col_q <= '0;
    end else if (step) begin
      if (last_col) begin
        col_q <= '0;
        row_q <= row_next;
      end else begin
        col_q <= col_q + CW'(1);
      end
    end
  end

  // Row base address: a shift when the row length is a power of two.
  generate
    if ((COLS & (COLS - 1)) == 0) begin : g_shift_base
      localparam int SH = $clog2(COLS);
      assign line_addr      = DDADDR_W'(row_q) << SH;
      assign next_line_addr = DDADDR_W'(row_next) << SH;
    end else begin : g_mult_base
      assign line_addr      = DDADDR_W'(row_q) * DDADDR_W'(COLS);
      assign next_line_addr = DDADDR_W'(row_next) * DDADDR_W'(COLS);
    end
  endgenerate

  // R3
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(row_q) < ROWS);

  // R3
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col_q) < COLS);

endmodule

// File: rtl/fmt_seq.sv
module fmt_seq
  import fmt_pkg::*;
#(
  parameter int TAB_LEN = 4,
  parameter int CW      = 4,
  parameter int CNT_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_cmd,
  input  logic [7:0]          in_data,
  output logic                in_ready,
  input  logic                slot_free,
  input  logic [CW-1:0]       pad_len,
  input  logic [DDADDR_W-1:0] line_addr,
  input  logic [DDADDR_W-1:0] next_line_addr,
  output logic                load,
  output lcd_word_t           word,
  output logic                step,
  output logic                go_origin,
  output logic                go_line_start,
  output logic                go_next_line
);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             nl_q, nl_d;
  logic             accept;
  ctl_op_e          op;

  assign in_ready = (st_q == SEQ_IDLE) && slot_free;
  assign accept   = in_valid && in_ready;
  assign op       = ctl_op_e'(in_data[7:6]);

  always_comb begin
    st_d          = st_q;
    cnt_d         = cnt_q;
    nl_d          = nl_q;
    load          = 1'b0;
    word          = '0;
    step          = 1'b0;
    go_origin     = 1'b0;
    go_line_start = 1'b0;
    go_next_line  = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (accept) begin
          if (in_cmd) begin
            unique case (op)
              OP_CLEAR: begin
                load      = 1'b1;
                word      = '{rs: 1'b0, val: LCD_CLEAR};
                go_origin = 1'b1;
              end
              OP_HOME: begin
                load      = 1'b1;
                word      = '{rs: 1'b0, val: LCD_HOME};
                go_origin = 1'b1;
              end
              OP_CGADDR: begin
                load = 1'b1;
                word = '{rs: 1'b0, val: LCD_CGADDR | {2'b00, in_data[5:0]}};
              end
              default: ;
            endcase
          end else begin
            unique case (in_data)
              CH_NUL: ;
              CH_TAB: begin
                st_d  = SEQ_PAD;
                cnt_d = CNT_W'(TAB_LEN);
                nl_d  = 1'b0;
              end
              CH_CR: begin
                load          = 1'b1;
                word          = '{rs: 1'b0, val: LCD_DDADDR | {1'b0, line_addr}};
                go_line_start = 1'b1;
              end
              CH_LF: begin
                nl_d = 1'b1;
                if (pad_len != '0) begin
                  st_d  = SEQ_PAD;
                  cnt_d = CNT_W'(pad_len);
                end else begin
                  st_d = SEQ_MOVE;
                end
              end
              default: begin
                load = 1'b1;
                word = '{rs: 1'b1, val: in_data};
                step = 1'b1;
              end
            endcase
          end
        end
      end
      SEQ_PAD: begin
        if (slot_free) begin
          load  = 1'b1;
          word  = '{rs: 1'b1, val: CH_SPACE};
          step  = 1'b1;
          cnt_d = cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) st_d = nl_q ? SEQ_MOVE : SEQ_IDLE;
        end
      end
      SEQ_MOVE: begin
        if (slot_free) begin
          load         = 1'b1;
          word         = '{rs: 1'b0, val: LCD_DDADDR | {1'b0, next_line_addr}};
          go_next_line = 1'b1;
          st_d         = SEQ_IDLE;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      nl_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      nl_q  <= nl_d;
    end
  end

  // R5
  pad_cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_PAD) |-> (cnt_q != '0));

  // R11
  busy_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SEQ_IDLE) |-> !in_ready);

endmodule

// File: rtl/fmt_outreg.sv
module fmt_outreg
  import fmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  lcd_word_t word,
  input  logic      out_ready,
  output logic      out_valid,
  output lcd_word_t out_word,
  output logic      slot_free
);

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (slot_free) begin
      out_valid <= load;
      if (load) out_word <= word;
    end
  end

  // R10
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && out_valid) |-> out_ready);

endmodule

// File: rtl/txt_cursor_fmt.sv
module txt_cursor_fmt
  import fmt_pkg::*;
#(
  parameter int ROWS    = 3,
  parameter int COLS    = 16,
  parameter int TAB_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_cmd,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_rs,
  output logic [7:0] out_byte
);

  localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW      = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int PAD_MAX = (TAB_LEN > COLS - 1) ? TAB_LEN : COLS - 1;
  localparam int CNT_W   = $clog2(PAD_MAX + 1);

  logic [RW-1:0]       row_q;
  logic [CW-1:0]       col_q;
  logic [DDADDR_W-1:0] line_addr;
  logic [DDADDR_W-1:0] next_line_addr;
  logic [CW-1:0]       pad_len;
  logic                step, go_origin, go_line_start, go_next_line;
  logic                load, slot_free;
  lcd_word_t           word, out_word;

  fmt_cursor #(
    .ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)
  ) u_cursor (
    .clk           (clk),
    .rst_n         (rst_n),
    .step          (step),
    .go_origin     (go_origin),
    .go_line_start (go_line_start),
    .go_next_line  (go_next_line),
    .row_q         (row_q),
    .col_q         (col_q),
    .line_addr     (line_addr),
    .next_line_addr(next_line_addr),
    .pad_len       (pad_len)
  );

  fmt_seq #(
    .TAB_LEN(TAB_LEN), .CW(CW), .CNT_W(CNT_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_cmd        (in_cmd),
    .in_data       (in_data),
    .in_ready      (in_ready),
    .slot_free     (slot_free),
    .pad_len       (pad_len),
    .line_addr     (line_addr),
    .next_line_addr(next_line_addr),
    .load          (load),
    .word          (word),
    .step          (step),
    .go_origin     (go_origin),
    .go_line_start (go_line_start),
    .go_next_line  (go_next_line)
  );

  fmt_outreg u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .word     (word),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_word (out_word),
    .slot_free(slot_free)
  );

  assign out_rs   = out_word.rs;
  assign out_byte = out_word.val;

endmodule

// File: tb/tb_txt_cursor_fmt.sv
module tb_txt_cursor_fmt;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_cmd = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_rs;
  logic [7:0] out_byte;

  int checks = 0;
  int fails  = 0;
  bit rnd_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  typedef struct {
    bit         rs;
    logic [7:0] b;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  int row = 1;
  int col = 1;

  bit         stall_prev = 1'b0;
  bit         prev_rs;
  logic [7:0] prev_byte;

  always #5 clk = ~clk;

  txt_cursor_fmt dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cmd(in_cmd), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_rs(out_rs), .out_byte(out_byte)
  );

  task automatic check(bit ok, string req, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic void push(bit rs, logic [7:0] b, string req);
    exp_t e;
    e.rs = rs; e.b = b; e.req = req;
    exp_q.push_back(e);
  endfunction

  function automatic void put_char(logic [7:0] ch, string req);
    push(1'b1, ch, req);
    col++;
    if (col > 16) begin
      col = 1;
      row++;
      if (row > 3) row = 1;   // R3
    end
  endfunction

  function automatic void model(bit c, logic [7:0] d);
    if (c) begin
      case (d[7:6])
        2'b00: begin push(1'b0, 8'h01, "R7"); row = 1; col = 1; end
        2'b01: begin push(1'b0, 8'h02, "R7"); row = 1; col = 1; end
        2'b10: push(1'b0, 8'h40 | {2'b00, d[5:0]}, "R8");
        default: ;            // R9
      endcase
    end else begin
      case (d)
        8'h00: ;              // R9
        8'h09: for (int k = 0; k < 4; k++) put_char(8'h20, "R5");
        8'h0D: begin push(1'b0, 8'(8'h80 | ((row - 1) * 16)), "R4"); col = 1; end
        8'h0A: begin
          while (col < 16) begin push(1'b1, 8'h20, "R6"); col++; end
          row++;
          if (row > 3) row = 1;
          col = 1;
          push(1'b0, 8'(8'h80 | ((row - 1) * 16)), "R6");
        end
        default: put_char(d, "R2");
      endcase
    end
  endfunction

  // Reference comparison on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        check(out_valid && out_rs == prev_rs && out_byte == prev_byte, "R10",
              $sformatf("held word changed: got v=%0d rs=%0d byte=%02h, expected v=1 rs=%0d byte=%02h",
                        out_valid, out_rs, out_byte, prev_rs, prev_byte));
      end
      stall_prev = out_valid && !out_ready;
      prev_rs    = out_rs;
      prev_byte  = out_byte;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", $sformatf("unexpected write: got rs=%0d byte=%02h, expected none",
                                      out_rs, out_byte));
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_rs == e.rs && out_byte == e.b, e.req,
                $sformatf("got rs=%0d byte=%02h, expected rs=%0d byte=%02h",
                          out_rs, out_byte, e.rs, e.b));
        end
      end
      if (in_valid && in_ready) begin
        check(exp_q.size() == 0, "R11",
              $sformatf("input taken with writes pending: got %0d pending, expected 0",
                        exp_q.size()));
        model(in_cmd, in_data);
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (rnd_mode) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[5];
    end
  end

  task automatic send(bit c, logic [7:0] d);
    in_valid = 1'b1; in_cmd = c; in_data = d;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #2;
    in_valid = 1'b0;
  endtask

  task automatic send_str(string s);
    for (int i = 0; i < s.len(); i++) send(1'b0, s[i]);
  endtask

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !out_valid) break;
    end
    check(exp_q.size() == 0 && !out_valid, "R9",
          $sformatf("after drain: got %0d pending, out_valid=%0d, expected 0 and 0",
                    exp_q.size(), out_valid));
    @(posedge clk);
    #2;
  endtask

  task automatic traffic();
    send(1'b0, 8'h0D);                  // R1: home position shows as 0x80
    send_str("Hi");                     // R2
    send(1'b0, 8'h0D);                  // R4
    send_str("abcdefghijklmnop");       // R3: 16 chars wrap to row 2
    send(1'b0, 8'h0D);
    send_str("x");
    send(1'b0, 8'h09);                  // R5
    send(1'b0, 8'h0A);                  // R6: from column 6
    send_str("ABCDEFGHIJKLM");
    send(1'b0, 8'h09);                  // R5: across row 3 -> row 1
    send(1'b0, 8'h0D);
    send(1'b0, 8'h0A);                  // R6: from column 1
    send_str("123456789012345");
    send(1'b0, 8'h0A);                  // R6: from column 16, no padding
    send(1'b0, 8'h0A);                  // R6: row 3 -> row 1
    send_str("q");
    send(1'b1, 8'h85);                  // R8
    send(1'b0, 8'h0D);                  // R8: position kept
    send(1'b0, 8'h00);                  // R9
    send(1'b1, 8'hC0);                  // R9
    send_str("Z");
    send(1'b1, 8'h00);                  // R7 clear
    send(1'b0, 8'h0D);
    send_str("mn");
    send(1'b0, 8'h0A);
    send_str("k");
    send(1'b1, 8'h40);                  // R7 home
    send(1'b0, 8'h0D);
  endtask

  initial begin : main
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!out_valid, "R1", $sformatf("out_valid after reset: got %0d, expected 0", out_valid));
    check(in_ready, "R1", $sformatf("in_ready after reset: got %0d, expected 1", in_ready));
    @(posedge clk);
    #2;
    traffic();
    drain();
    rnd_mode = 1'b1;                    // R10, R11 under back-pressure
    traffic();
    rnd_mode = 1'b0;
    out_ready = 1'b1;
    drain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got run still active, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule